// File: doc/BRIEF.md
# Nibble-Mode Reverse Channel Sender

This block sits on the peripheral side of a parallel link and carries bytes back to the host over four status lines, four bits at a time. It takes one byte from a local valid/ready source, splits it into a low and a high half, and paces each half with a strobe/acknowledge handshake against the host's busy line. After the second half has been acknowledged, the same four lines carry a short status word: whether the peripheral is busy and whether another byte is waiting.

The host's busy line is asynchronous to the block clock. It passes through a synchroniser chain and a stability filter before the phase sequencer uses it, so a short glitch never advances the transfer. The four outputs map to the status lines S3, S4, S5 and S7 in that order. The spare line S6 is left to other uses and is not driven here.

Top module: `nib_rev_sender`

## Requirements
- R1: After reset the strobe output `ptr_clk_n` is high, `src_ready` is high, and `sline` reads 4'b0001, meaning not busy and no data pending.
- R2: A byte is taken only when `src_valid` and `src_ready` are both high. `src_ready` stays low from that edge until the status phase ends. Values offered on `src_data` in that window are ignored.
- R3: Once a byte has been taken, neither `sline` nor `ptr_clk_n` changes while the filtered host busy level stays high.
- R4: The first half sent is data bits 3:0 and the second half is bits 7:4. Within a half, bit 0 drives `sline[0]` (S3), bit 1 drives `sline[1]` (S4), bit 2 drives `sline[2]` (S5) and bit 3 drives `sline[3]` (S7).
- R5: Each half is placed on `sline` one clock before `ptr_clk_n` falls, and it stays unchanged while the strobe is low.
- R6: When the host raises its busy line to acknowledge the first half, `ptr_clk_n` returns high.
- R7: The second half appears only after the host drives its busy line low again. After that half is acknowledged, `sline` changes to the status word.
- R8: The status word is `{periph_busy, 0, 0, ~more}`, where `more` is `src_valid` sampled at the second acknowledge. `ptr_clk_n` stays low for one clock with the status word on the lines, then rises, and `src_ready` returns high in that same clock.
- R9: A change of `host_busy` that lasts less than `STABLE` clocks after synchronisation is ignored.
- R10: A change of `host_busy` driven just after a clock edge shows on the outputs exactly `SYNC_N + STABLE + 1` rising edges later, which is 5 edges with the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Local source has a byte; also acts as the "more data" indication |
| src_data | input | 8 | Byte to return to the host |
| src_ready | output | 1 | High while idle and able to take a byte |
| periph_busy | input | 1 | Local busy flag, reported in the status word |
| host_busy | input | 1 | Host busy line, asynchronous |
| sline | output | 4 | Status lines S3, S4, S5, S7 (bits 0..3) |
| ptr_clk_n | output | 1 | Active-low data strobe to the host |

## Verification
Acceptance shows on `src_ready` one edge after a source offer. Every host-line change reaches the outputs five rising edges later, made up of two synchroniser stages, two clocks of the stability filter and one clock for the state register. A nibble appears on the lines one edge before its strobe falls. The bench drives inputs on the falling edge and samples on a later falling edge. It checks that nothing has changed after four rising edges and that the new value is present after five. For each table entry it walks the handshake with these exact counts and checks both halves, the status word and the release of `src_ready`. Separate directed passes cover the reset state, a one-clock glitch on the host line, and a reset in the middle of a transfer.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

  localparam int BYTE_W = 8;
  localparam int HALF_W = BYTE_W / 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_A,
    ST_SET_A,
    ST_STB_A,
    ST_WAIT_B,
    ST_SET_B,
    ST_STB_B,
    ST_STAT
  } nrs_state_e;

  // choose low (hi_sel=0) or high half of a byte
  function automatic logic [HALF_W-1:0] half_of(input logic [BYTE_W-1:0] b,
                                                input logic hi_sel);
    return hi_sel ? b[BYTE_W-1:HALF_W] : b[HALF_W-1:0];
  endfunction

  // half bit k drives line index k (S3,S4,S5,S7)
  function automatic logic [HALF_W-1:0] to_lines(input logic [HALF_W-1:0] h);
    logic [HALF_W-1:0] r;
    for (int k = 0; k < HALF_W; k++) r[k] = h[k];
    return r;
  endfunction

  // status word: line3 = busy, line0 = nothing pending
  function automatic logic [HALF_W-1:0] status_word(input logic busy,
                                                    input logic more);
    logic [HALF_W-1:0] r;
    r = '0;
    r[HALF_W-1] = busy;
    r[0] = ~more;
    return r;
  endfunction

endpackage

// File: rtl/nrs_hb_filter.sv
module nrs_hb_filter #(
  parameter int SYNC_N = 2,
  parameter int STABLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_async,
  output logic hb_filt
);

  localparam int CW = (STABLE < 2) ? 1 : $clog2(STABLE + 1);

  logic [SYNC_N-1:0] chain;
  logic              sync_lvl;
  logic [CW-1:0]     cnt;

  generate
    for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= hb_async;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign sync_lvl = chain[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_filt <= 1'b1;
      cnt     <= '0;
    end else if (sync_lvl == hb_filt) begin
      cnt <= '0;
    end else if (cnt == CW'(STABLE - 1)) begin
      hb_filt <= sync_lvl;
      cnt     <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // the filtered level only moves toward a level the chain already held
  assert_filter_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_filt != $past(hb_filt)) |-> ($past(sync_lvl) != $past(hb_filt)));

endmodule

// File: rtl/nrs_seq_fsm.sv
module nrs_seq_fsm
  import nrs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [BYTE_W-1:0] src_data,
  input  logic              periph_busy,
  input  logic              hb_filt,
  output nrs_state_e        state,
  output logic [BYTE_W-1:0] byte_q,
  output logic [HALF_W-1:0] stat_q,
  output logic              accept
);

  assign accept = (state == ST_IDLE) && src_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      byte_q <= '0;
      stat_q <= status_word(1'b0, 1'b0);
    end else begin
      unique case (state)
        ST_IDLE:   if (src_valid) begin
                     byte_q <= src_data;
                     state  <= ST_WAIT_A;
                   end
        ST_WAIT_A: if (!hb_filt) state <= ST_SET_A;
        ST_SET_A:  state <= ST_STB_A;
        ST_STB_A:  if (hb_filt) state <= ST_WAIT_B;
        ST_WAIT_B: if (!hb_filt) state <= ST_SET_B;
        ST_SET_B:  state <= ST_STB_B;
        ST_STB_B:  if (hb_filt) begin
                     stat_q <= status_word(periph_busy, src_valid);
                     state  <= ST_STAT;
                   end
        ST_STAT:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // no progress out of the first wait while the host stays busy
  assert_hold_until_host_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_A && hb_filt) |=> (state == ST_WAIT_A));

  // the second half is never set up while the host is still busy
  assert_second_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SET_B) |-> $past(!hb_filt));

endmodule

// File: rtl/nrs_line_drive.sv
module nrs_line_drive
  import nrs_pkg::*;
(
  input  nrs_state_e        state,
  input  logic [BYTE_W-1:0] byte_q,
  input  logic [HALF_W-1:0] stat_q,
  output logic [HALF_W-1:0] lines,
  output logic              strobe_n
);

  always_comb begin
    unique case (state)
      ST_SET_A, ST_STB_A, ST_WAIT_B: lines = to_lines(half_of(byte_q, 1'b0));
      ST_SET_B, ST_STB_B:            lines = to_lines(half_of(byte_q, 1'b1));
      default:                       lines = stat_q;
    endcase
  end

  assign strobe_n = !(state == ST_STB_A || state == ST_STB_B || state == ST_STAT);

endmodule

// File: rtl/nib_rev_sender.sv
module nib_rev_sender
  import nrs_pkg::*;
#(
  parameter int SYNC_N = 2,
  parameter int STABLE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_valid,
  input  logic [7:0]  src_data,
  output logic        src_ready,
  input  logic        periph_busy,
  input  logic        host_busy,
  output logic [3:0]  sline,
  output logic        ptr_clk_n
);

  logic              hb_filt;
  nrs_state_e        state;
  logic [BYTE_W-1:0] byte_q;
  logic [HALF_W-1:0] stat_q;
  logic              accept;

  nrs_hb_filter #(.SYNC_N(SYNC_N), .STABLE(STABLE)) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .hb_async (host_busy),
    .hb_filt  (hb_filt)
  );

  nrs_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_valid   (src_valid),
    .src_data    (src_data),
    .periph_busy (periph_busy),
    .hb_filt     (hb_filt),
    .state       (state),
    .byte_q      (byte_q),
    .stat_q      (stat_q),
    .accept      (accept)
  );

  nrs_line_drive u_drv (
    .state    (state),
    .byte_q   (byte_q),
    .stat_q   (stat_q),
    .lines    (sline),
    .strobe_n (ptr_clk_n)
  );

  assign src_ready = (state == ST_IDLE);

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !src_ready);

  assert_ready_strobe_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> ptr_clk_n);

  assert_setup_before_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ptr_clk_n) |-> $stable(sline));

  assert_release_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ptr_clk_n) |-> $past(hb_filt));

  assert_status_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STAT) |=> (src_ready && ptr_clk_n));

endmodule

// File: tb/sim_nib_rev_sender.sv
module sim_nib_rev_sender;

  localparam int LAT = 5;  // SYNC_N + STABLE + 1 with defaults

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_valid = 1'b0;
  logic [7:0] src_data = '0;
  logic       src_ready;
  logic       periph_busy = 1'b0;
  logic       host_busy = 1'b1;
  logic [3:0] sline;
  logic       ptr_clk_n;

  int checks = 0;
  int errors = 0;
  logic [3:0] last_stat = 4'b0001;

  always #2 clk = ~clk;

  nib_rev_sender u0 (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .periph_busy(periph_busy), .host_busy(host_busy),
    .sline(sline), .ptr_clk_n(ptr_clk_n)
  );

  // {data, busy, more, expected first half, expected second half}
  localparam logic [17:0] VEC [6] = '{
    {8'hA5, 1'b0, 1'b0, 4'h5, 4'hA},
    {8'h3C, 1'b1, 1'b0, 4'hC, 4'h3},
    {8'h00, 1'b0, 1'b1, 4'h0, 4'h0},
    {8'hFF, 1'b1, 1'b1, 4'hF, 4'hF},
    {8'h81, 1'b0, 1'b0, 4'h1, 4'h8},
    {8'h7E, 1'b1, 1'b1, 4'hE, 4'h7}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_byte(input logic [7:0] d, input logic busy, input logic more,
                          input logic [3:0] lo, input logic [3:0] hi, input logic glitch);
    logic [3:0] st;
    st = {busy, 2'b00, ~more};
    periph_busy = busy;
    src_valid = 1'b1;
    src_data = d;
    edges(1);
    chk("R2 ready low after accept", {7'd0, src_ready}, 8'd0);
    src_valid = more;
    src_data = ~d;                       // decoy that must be ignored
    edges(3);
    chk("R3 strobe idle while host busy", {7'd0, ptr_clk_n}, 8'd1);
    chk("R3 lines hold while host busy", {4'd0, sline}, {4'd0, last_stat});
    if (glitch) begin
      host_busy = 1'b0;
      edges(1);
      host_busy = 1'b1;
      edges(10);
      chk("R9 glitch ignored strobe", {7'd0, ptr_clk_n}, 8'd1);
      chk("R9 glitch ignored lines", {4'd0, sline}, {4'd0, last_stat});
    end
    host_busy = 1'b0;
    edges(LAT - 1);
    chk("R10 no early setup", {4'd0, sline}, {4'd0, last_stat});
    edges(1);
    chk("R4 first half on lines", {4'd0, sline}, {4'd0, lo});
    chk("R5 strobe high during setup", {7'd0, ptr_clk_n}, 8'd1);
    edges(1);
    chk("R5 strobe low", {7'd0, ptr_clk_n}, 8'd0);
    chk("R5 half held under strobe", {4'd0, sline}, {4'd0, lo});
    host_busy = 1'b1;
    edges(LAT - 1);
    chk("R10 strobe not yet released", {7'd0, ptr_clk_n}, 8'd0);
    edges(1);
    chk("R6 strobe released on ack", {7'd0, ptr_clk_n}, 8'd1);
    edges(6);
    chk("R7 no second half while host busy", {4'd0, sline}, {4'd0, lo});
    host_busy = 1'b0;
    edges(LAT);
    chk("R7 second half on lines", {4'd0, sline}, {4'd0, hi});
    chk("R7 strobe high during setup", {7'd0, ptr_clk_n}, 8'd1);
    edges(1);
    chk("R7 second strobe low", {7'd0, ptr_clk_n}, 8'd0);
    host_busy = 1'b1;
    edges(LAT);
    chk("R8 status word", {4'd0, sline}, {4'd0, st});
    chk("R8 strobe low with status", {7'd0, ptr_clk_n}, 8'd0);
    chk("R8 ready still low", {7'd0, src_ready}, 8'd0);
    edges(1);
    chk("R8 strobe rises", {7'd0, ptr_clk_n}, 8'd1);
    chk("R8 ready back", {7'd0, src_ready}, 8'd1);
    chk("R8 status held", {4'd0, sline}, {4'd0, st});
    src_valid = 1'b0;
    last_stat = st;
    edges(2);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    edges(3);
    chk("R1 reset strobe", {7'd0, ptr_clk_n}, 8'd1);
    chk("R1 reset lines", {4'd0, sline}, 8'h01);
    rst_n = 1'b1;
    edges(2);
    chk("R1 idle ready", {7'd0, src_ready}, 8'd1);
    chk("R1 idle lines", {4'd0, sline}, 8'h01);

    for (int i = 0; i < 6; i++)
      run_byte(VEC[i][17:10], VEC[i][9], VEC[i][8], VEC[i][7:4], VEC[i][3:0], 1'b0);

    // glitch on host line while waiting for the first half (R9)
    run_byte(8'h96, 1'b0, 1'b0, 4'h6, 4'h9, 1'b1);

    // reset in the middle of a strobe (R1)
    src_valid = 1'b1;
    src_data = 8'h5A;
    edges(1);
    src_valid = 1'b0;
    host_busy = 1'b0;
    edges(LAT + 1);
    chk("R5 strobe low before reset", {7'd0, ptr_clk_n}, 8'd0);
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset strobe", {7'd0, ptr_clk_n}, 8'd1);
    chk("R1 mid reset lines", {4'd0, sline}, 8'h01);
    chk("R1 mid reset ready", {7'd0, src_ready}, 8'd1);
    host_busy = 1'b1;
    edges(2);
    rst_n = 1'b1;
    last_stat = 4'b0001;
    edges(6);
    run_byte(8'hC3, 1'b1, 1'b0, 4'h3, 4'hC, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule